// File: doc/BRIEF.md
# Four-Channel DMA Request Priority Resolver

This block decides which of four DMA request lines is served next. Each channel has a request input and an enable bit, and a channel whose enable bit is clear is never picked. A single mode input chooses the ordering. In fixed mode channel 0 always wins over 1, 1 over 2, and 2 over 3. In rotating mode the channel that was just served moves to the bottom of the order.

A winning channel is captured into a grant register and held there until the surrounding controller pulses `done_i` to report that its service has finished. On that pulse the grant is released. In rotating mode the pulse also moves the rotation pointer to the channel just after the one served. The next grant is decided at the following clock edge. The handshake with the processor and the data transfers themselves belong to other blocks.

Top module: `dma_prio_arb`

## Requirements
- R1: At most one bit of `gnt_o` is set, and `gnt_valid_o` is high exactly when one bit is set. Bit n of `gnt_o` stands for channel n.
- R2: During reset, and after any edge at which no grant was held and no channel had both `req_i[n]` and `en_i[n]` high, `gnt_o` is all zeros and `gnt_valid_o` is low.
- R3: A new grant is captured only for a channel whose request bit and enable bit were both 1 at the capturing edge. Bit n of `en_i` gates channel n.
- R4: With `rotate_i` = 0 (fixed mode), the lowest-numbered eligible channel wins. The order is 0 > 1 > 2 > 3.
- R5: With `rotate_i` = 1, after service of channel k completes, the order for the following arbitrations is k+1, k+2, ... wrapping modulo 4, with k last.
- R6: Rotating order starts at 0 > 1 > 2 > 3 after reset. Any edge with `rotate_i` = 0 returns the rotation pointer to channel 0.
- R7: A held grant stays unchanged while `done_i` is low and its channel's enable bit stays high, even if its request drops or a higher-priority request arrives.
- R8: `done_i` high at an edge while a grant is held releases it at that edge. The next grant can be captured no earlier than the following edge.
- R9: If the held channel's enable bit is 0 at an edge, and `done_i` is low, the grant is released at that edge and the rotation pointer does not move.
- R10: `done_i` at an edge with no grant held is ignored and leaves the rotation pointer unchanged.

Top module port list:

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | NUM_CH | Request line per channel |
| en_i | input | NUM_CH | Enable mask per channel |
| rotate_i | input | 1 | 1 = rotating priority, 0 = fixed priority |
| done_i | input | 1 | Service-complete pulse for the held grant |
| gnt_o | output | NUM_CH | One-hot grant, zero when idle |
| gnt_valid_o | output | 1 | A grant is held |

## Verification
The properties assume that `done_i` is a single-cycle pulse issued only to end a held grant. They also assume that every input is stable around the rising edge. None of them depends on how long a channel keeps its request asserted. The directed stimulus changes inputs only on the falling edge. It raises `done_i` for exactly one cycle, and only once it means to release, with the one exception of the test that probes R10 on purpose. Requests are set to zero during release cycles whenever the next grant must be captured under a chosen pointer value.

// File: rtl/dma_prio_arb_pkg.sv
package dma_prio_arb_pkg;

  typedef enum logic {
    MODE_FIXED  = 1'b0,
    MODE_ROTATE = 1'b1
  } prio_mode_e;

endpackage

// File: rtl/dma_prio_pick.sv
// Round-robin lowest-first pick starting at ptr_i
module dma_prio_pick #(
  parameter int NUM_CH = 4,
  parameter int PTR_W  = 2
) (
  input  logic [NUM_CH-1:0] elig_i,
  input  logic [PTR_W-1:0]  ptr_i,
  output logic [NUM_CH-1:0] pick_o
);

  logic [NUM_CH-1:0] rot_all  [NUM_CH];
  logic [NUM_CH-1:0] back_all [NUM_CH];
  logic [NUM_CH-1:0] rot;
  logic [NUM_CH-1:0] lowest;

  // rot_all[p][j] = channel (p+j) mod N; back_all undoes it
  for (genvar p = 0; p < NUM_CH; p++) begin : g_ptr
    for (genvar j = 0; j < NUM_CH; j++) begin : g_bit
      assign rot_all[p][j]                  = elig_i[(p + j) % NUM_CH];
      assign back_all[p][(p + j) % NUM_CH]  = lowest[j];
    end
  end

  always_comb begin
    rot = '0;
    for (int p = 0; p < NUM_CH; p++) begin
      if (ptr_i == PTR_W'(p)) rot = rot_all[p];
    end
  end

  assign lowest = rot & (~rot + 1'b1);

  always_comb begin
    pick_o = '0;
    for (int p = 0; p < NUM_CH; p++) begin
      if (ptr_i == PTR_W'(p)) pick_o = back_all[p];
    end
  end

endmodule

// File: rtl/dma_rot_ptr.sv
module dma_rot_ptr #(
  parameter int NUM_CH = 4,
  parameter int PTR_W  = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             rotate_i,
  input  logic             adv_i,
  input  logic [PTR_W-1:0] served_i,
  output logic [PTR_W-1:0] ptr_o
);

  logic [PTR_W-1:0] ptr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ptr_q <= '0;
    end else if (!rotate_i) begin
      ptr_q <= '0;
    end else if (adv_i) begin
      ptr_q <= (served_i == PTR_W'(NUM_CH - 1)) ? '0 : served_i + 1'b1;
    end
  end

  assign ptr_o = ptr_q;

endmodule

// File: rtl/dma_grant_hold.sv
module dma_grant_hold #(
  parameter int NUM_CH = 4,
  parameter int PTR_W  = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NUM_CH-1:0] pick_i,
  input  logic [NUM_CH-1:0] en_i,
  input  logic              done_i,
  output logic [NUM_CH-1:0] gnt_o,
  output logic              busy_o,
  output logic              adv_o,
  output logic [PTR_W-1:0]  idx_o
);

  logic [NUM_CH-1:0] held_q, held_d;
  logic              masked;

  assign busy_o = |held_q;
  assign masked = |(held_q & ~en_i);

  always_comb begin
    held_d = held_q;
    if (busy_o) begin
      if (done_i || masked) held_d = '0;
    end else begin
      held_d = pick_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) held_q <= '0;
    else         held_q <= held_d;
  end

  // done beats a simultaneous mask drop: service counted as complete
  assign adv_o = busy_o & done_i;

  always_comb begin
    idx_o = '0;
    for (int i = 0; i < NUM_CH; i++) begin
      if (held_q[i]) idx_o = PTR_W'(i);
    end
  end

  assign gnt_o = held_q;

endmodule

// File: rtl/dma_prio_arb.sv
module dma_prio_arb
  import dma_prio_arb_pkg::*;
#(
  parameter int NUM_CH = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NUM_CH-1:0] req_i,
  input  logic [NUM_CH-1:0] en_i,
  input  logic              rotate_i,
  input  logic              done_i,
  output logic [NUM_CH-1:0] gnt_o,
  output logic              gnt_valid_o
);

  localparam int PTR_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;

  prio_mode_e        mode;
  logic [NUM_CH-1:0] elig;
  logic [NUM_CH-1:0] pick;
  logic [PTR_W-1:0]  ptr_q, ptr_eff, served_idx;
  logic              adv;

  assign mode    = prio_mode_e'(rotate_i);
  assign elig    = req_i & en_i;
  // fixed mode ignores the stored pointer in the same cycle it is selected
  assign ptr_eff = (mode == MODE_ROTATE) ? ptr_q : '0;

  dma_prio_pick #(.NUM_CH(NUM_CH), .PTR_W(PTR_W)) i_pick (
    .elig_i (elig),
    .ptr_i  (ptr_eff),
    .pick_o (pick)
  );

  dma_grant_hold #(.NUM_CH(NUM_CH), .PTR_W(PTR_W)) i_hold (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .pick_i (pick),
    .en_i   (en_i),
    .done_i (done_i),
    .gnt_o  (gnt_o),
    .busy_o (gnt_valid_o),
    .adv_o  (adv),
    .idx_o  (served_idx)
  );

  dma_rot_ptr #(.NUM_CH(NUM_CH), .PTR_W(PTR_W)) i_ptr (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .rotate_i (rotate_i),
    .adv_i    (adv),
    .served_i (served_idx),
    .ptr_o    (ptr_q)
  );

endmodule

// File: rtl/dma_prio_arb_chk.sv
module dma_prio_arb_chk #(
  parameter int NUM_CH = 4
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [NUM_CH-1:0] req_i,
  input logic [NUM_CH-1:0] en_i,
  input logic              rotate_i,
  input logic              done_i,
  input logic [NUM_CH-1:0] gnt_o,
  input logic              gnt_valid_o
);

  a_r1_onehot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(gnt_o));

  a_r2_stay_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!gnt_valid_o && ((req_i & en_i) == '0)) |=> !gnt_valid_o);

  a_r3_eligible: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !gnt_valid_o |=> ((gnt_o & ~($past(req_i) & $past(en_i))) == '0));

  a_r4_fixed_ch0: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!gnt_valid_o && !rotate_i && req_i[0] && en_i[0]) |=> gnt_o[0]);

  a_r7_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gnt_valid_o && !done_i && ((gnt_o & ~en_i) == '0)) |=> $stable(gnt_o));

  a_r8_release: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gnt_valid_o && done_i) |=> !gnt_valid_o);

  a_r9_mask_drop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gnt_valid_o && ((gnt_o & ~en_i) != '0)) |=> !gnt_valid_o);

endmodule

bind dma_prio_arb dma_prio_arb_chk #(.NUM_CH(NUM_CH)) i_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .req_i       (req_i),
  .en_i        (en_i),
  .rotate_i    (rotate_i),
  .done_i      (done_i),
  .gnt_o       (gnt_o),
  .gnt_valid_o (gnt_valid_o)
);

// File: tb/test_dma_prio_arb.sv
module test_dma_prio_arb;

  logic       clk_i = 1'b0;
  logic       rst_ni;
  logic [3:0] req_i, en_i;
  logic       rotate_i, done_i;
  logic [3:0] gnt_o;
  logic       gnt_valid_o;

  int n_chk  = 0;
  int n_fail = 0;

  always #5 clk_i = ~clk_i;

  dma_prio_arb #(.NUM_CH(4)) i_dma_prio_arb (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .req_i       (req_i),
    .en_i        (en_i),
    .rotate_i    (rotate_i),
    .done_i      (done_i),
    .gnt_o       (gnt_o),
    .gnt_valid_o (gnt_valid_o)
  );

  task automatic step();
    @(posedge clk_i);
    @(negedge clk_i);
  endtask

  task automatic check(string tag, logic [3:0] exp);
    n_chk++;
    if (gnt_o !== exp || gnt_valid_o !== (exp != 4'b0)) begin
      n_fail++;
      $display("FAIL %s: gnt=%b valid=%b expected gnt=%b valid=%b",
               tag, gnt_o, gnt_valid_o, exp, exp != 4'b0);
    end
  endtask

  task automatic do_reset();
    rst_ni = 1'b0; req_i = '0; en_i = '0; rotate_i = 1'b0; done_i = 1'b0;
    step();
    rst_ni = 1'b1;
  endtask

  task automatic release_gnt(string tag);
    done_i = 1'b1;
    step();
    done_i = 1'b0;
    check(tag, 4'b0000);
  endtask

  task automatic t_reset();
    rst_ni = 1'b0; req_i = 4'hF; en_i = 4'hF; rotate_i = 1'b0; done_i = 1'b0;
    step();
    check("R2 in reset", 4'b0000);
    req_i = '0;
    rst_ni = 1'b1;
    step();
    check("R2 after reset, no request", 4'b0000);
    req_i = 4'hF; en_i = 4'h0;
    step();
    check("R3 all disabled", 4'b0000);
  endtask

  task automatic t_fixed();
    do_reset();
    en_i = 4'hF; req_i = 4'b1110;
    step(); check("R4 req 1110", 4'b0010);
    req_i = 4'b1100; release_gnt("R8 release fixed");
    step(); check("R4 req 1100", 4'b0100);
    req_i = 4'b1000; release_gnt("R8 release fixed");
    step(); check("R4 req 1000", 4'b1000);
    req_i = 4'b1111; release_gnt("R8 release fixed");
    step(); check("R4 req 1111", 4'b0001);
    release_gnt("R8 release fixed");
    step(); check("R4 fixed repeats ch0", 4'b0001);
  endtask

  task automatic t_mask();
    do_reset();
    en_i = 4'b1010; req_i = 4'b1111;
    step(); check("R3 mask 1010", 4'b0010);
    en_i = 4'b0100; req_i = 4'b1011;
    release_gnt("R8 release mask");
    step(); check("R3 requester disabled", 4'b0000);
  endtask

  task automatic t_hold();
    do_reset();
    en_i = 4'hF; req_i = 4'b0100;
    step(); check("R7 initial grant", 4'b0100);
    req_i = 4'b0001;
    step(); check("R7 held vs higher request", 4'b0100);
    step(); check("R7 held after request drop", 4'b0100);
    release_gnt("R8 release hold");
    step(); check("R8 next grant after idle cycle", 4'b0001);
  endtask

  task automatic t_rotate();
    do_reset();
    rotate_i = 1'b1; en_i = 4'hF; req_i = 4'hF;
    step(); check("R6 rotate start ch0", 4'b0001);
    release_gnt("R8 release rot");
    step(); check("R5 after ch0", 4'b0010);
    release_gnt("R8 release rot");
    step(); check("R5 after ch1", 4'b0100);
    release_gnt("R8 release rot");
    step(); check("R5 after ch2", 4'b1000);
    release_gnt("R8 release rot");
    step(); check("R5 wrap after ch3", 4'b0001);
    req_i = 4'b1001;
    release_gnt("R8 release rot");
    step(); check("R5 ch0 lowest, ch3 wins", 4'b1000);
  endtask

  task automatic t_switch();
    do_reset();
    rotate_i = 1'b1; en_i = 4'hF; req_i = 4'hF;
    step(); check("R6 rotate ch0", 4'b0001);
    release_gnt("R8 release sw");
    step(); check("R5 rotate ch1", 4'b0010);
    req_i = '0;
    release_gnt("R8 release sw");
    rotate_i = 1'b0;
    step(); check("R2 idle in fixed", 4'b0000);
    rotate_i = 1'b1; req_i = 4'hF;
    step(); check("R6 restart at ch0 after fixed", 4'b0001);
  endtask

  task automatic t_done_idle();
    do_reset();
    rotate_i = 1'b1; en_i = 4'hF; req_i = 4'hF;
    step(); check("R6 ch0", 4'b0001);
    release_gnt("R8 release idle");
    step(); check("R5 ch1", 4'b0010);
    req_i = '0;
    release_gnt("R8 release idle");
    done_i = 1'b1;
    step();
    done_i = 1'b0;
    check("R10 done while idle", 4'b0000);
    req_i = 4'hF;
    step(); check("R10 pointer kept at ch2", 4'b0100);
  endtask

  task automatic t_mask_drop();
    do_reset();
    rotate_i = 1'b1; en_i = 4'hF; req_i = 4'hF;
    step(); check("R9 setup ch0", 4'b0001);
    req_i = '0; en_i = 4'b1110;
    step(); check("R9 grant dropped on mask", 4'b0000);
    en_i = 4'hF; req_i = 4'hF;
    step(); check("R9 pointer not advanced", 4'b0001);
  endtask

  initial begin
    #2_000_000;
    n_fail++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    rst_ni = 1'b0; req_i = '0; en_i = '0; rotate_i = 1'b0; done_i = 1'b0;
    @(negedge clk_i);
    t_reset();
    t_fixed();
    t_mask();
    t_hold();
    t_rotate();
    t_switch();
    t_done_idle();
    t_mask_drop();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule